// File: doc/BRIEF.md
# Receiver Clock and Data Source Selector

This block chooses where a digital audio receiver takes its master clock and its serial data output from. There are two candidates. The first is the clock recovered by the receiver's PLL, paired with the data recovered from the incoming stream. The second is the local crystal clock, paired with an auxiliary serial data input. A 2-bit operating-mode field makes the choice. In one mode the choice also depends on whether the PLL is locked.

The block produces the lock status itself. It counts crystal-clock cycles between the frame sync pulses that the receiver reports, and it checks each interval against a window given by `win_min` and `win_max`. The clock multiplexer is glitch-free. Each clock has an enable made of two flops that update on that clock's falling edge, and the enable of the new clock rises only after the enable of the old clock has dropped. The data source is taken from the same enable, so the output data always comes from the source whose clock is driving the output.

Top module: `rx_clk_src_sel`

Operating modes (`mode`): 2'b00 means PLL clock with recovered data. 2'b01 means crystal clock with auxiliary data, and the PLL is off. 2'b10 means PLL while locked and crystal while unlocked. 2'b11 means crystal with auxiliary data, and the PLL stays on.

The lock monitor is a state machine with three states:
- `LK_IDLE`: there is no reference pulse yet.
- `LK_HUNT`: the monitor is counting good intervals.
- `LK_LOCKED`: the PLL is treated as locked.

Its transitions are:
- *first_sync*: IDLE to HUNT, on any pulse.
- *good_run_done*: HUNT to LOCKED, on the LOCK_CNT-th consecutive in-window interval.
- *bad_interval*: HUNT to HUNT with the count cleared, or LOCKED to HUNT, on a pulse whose interval is out of the window.
- *interval_timeout*: HUNT or LOCKED to IDLE, when `win_max` cycles pass with no pulse.
- *pll_off*: any state to IDLE, while the mode is 2'b01.

## Requirements
- R1: In mode 2'b00, `mclk_out` follows `pll_clk` and `sdata_out` equals `rx_data` once the switch has settled, whatever the lock state.
- R2: In mode 2'b01, `mclk_out` follows `xtal_clk` and `sdata_out` equals `aux_data`.
- R3: In mode 2'b10, the outputs use `pll_clk` with `rx_data` while `unlock` is 0, and `xtal_clk` with `aux_data` while `unlock` is 1.
- R4: In mode 2'b11, the outputs always use `xtal_clk` with `aux_data`, while the lock monitor keeps running so that `unlock` can still fall to 0.
- R5: `pll_en` is 0 only in mode 2'b01. In that mode the monitor is held in `LK_IDLE`, so `unlock` is 1 at the next crystal edge and stays 1 even when valid pulses arrive.
- R6: An interval is the number of rising `xtal_clk` edges from one sampled `frame_sync` pulse to the next. It is in window when `win_min <= interval <= win_max`, with both limits inclusive. While locked, a pulse whose interval is out of the window raises `unlock` at that same edge.
- R7: While locked, if `win_max` rising edges pass after a pulse with no further pulse, `unlock` rises at edge number `win_max`. A pulse that arrives exactly `win_max` edges after the previous one keeps the lock.
- R8: Coming from `LK_IDLE`, the first pulse is only a reference. `unlock` falls after LOCK_CNT consecutive in-window intervals (4 by default). An out-of-window interval during the hunt restarts that count.
- R9: At most one clock enable is active at any time. `mclk_out` is high only while the clock that is currently enabled is high, and the new clock is enabled only after the old one has been disabled on its falling edge.
- R10: The data source changes together with the clock enable. Whenever `mclk_out` is driven from `pll_clk`, `sdata_out` equals `rx_data`. Whenever it is driven from `xtal_clk`, `sdata_out` equals `aux_data`.
- R11: During reset, `unlock` is 1, no clock is enabled (so `mclk_out` is 0), and `sdata_out` equals `aux_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk | input | 1 | Crystal clock. It also clocks the lock monitor. |
| pll_clk | input | 1 | Clock recovered by the PLL |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode selecting the clock and data source |
| frame_sync | input | 1 | One-cycle frame sync pulse, synchronous to `xtal_clk` |
| rx_data | input | 1 | Serial data recovered by the receiver |
| aux_data | input | 1 | Auxiliary serial data input |
| win_min | input | CNT_W | Smallest interval, in crystal cycles, that counts as good |
| win_max | input | CNT_W | Largest interval, in crystal cycles, that counts as good |
| mclk_out | output | 1 | Selected master clock |
| sdata_out | output | 1 | Selected serial data |
| unlock | output | 1 | 1 while the PLL is not considered locked |
| pll_en | output | 1 | 1 when the PLL should be powered |

## Verification
A monitor stuck in, or wrongly leaving, `LK_LOCKED` shows on `unlock` at the very crystal edge that samples the offending pulse or the missing one. In mode 2'b10, the same fault shows on `mclk_out` a few cycles later, about two falling edges of each clock. A fault in the handshake shows at the ports within a few clock periods of a source change, in either of two ways:
- `mclk_out` is high while no enabled source is high.
- `sdata_out` does not match the clock that is currently running.

The monitor's boundary cases are exercised separately: intervals equal to each window limit, intervals one cycle outside the window, and a bad interval in the middle of the hunt.

// File: rtl/rx_css_pkg.sv
package rx_css_pkg;

    typedef enum logic [1:0] {
        LK_IDLE   = 2'd0,
        LK_HUNT   = 2'd1,
        LK_LOCKED = 2'd2
    } lk_state_e;

    typedef enum logic [1:0] {
        MODE_PLL     = 2'b00,
        MODE_XTAL    = 2'b01,
        MODE_AUTO    = 2'b10,
        MODE_MONITOR = 2'b11
    } cm_e;

endpackage

// File: rtl/rx_lock_mon.sv
module rx_lock_mon
    import rx_css_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int LOCK_CNT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sync,
    input  logic [CNT_W-1:0] win_min,
    input  logic [CNT_W-1:0] win_max,
    output logic             unlock
);
    localparam int               GOOD_W    = $clog2(LOCK_CNT + 1);
    localparam logic [CNT_W-1:0] CNT_SAT   = '1;
    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_CNT - 1);

    lk_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [GOOD_W-1:0] good_q, good_d;
    logic              in_win, expired;

    // Interval counter: holds the number of edges since the last pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (sync)           cnt_q <= CNT_W'(1);
        else if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end

    assign in_win  = (cnt_q >= win_min) && (cnt_q <= win_max);
    assign expired = !sync && (cnt_q >= win_max);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_IDLE;
            good_q  <= '0;
        end else begin
            state_q <= state_d;
            good_q  <= good_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        good_d  = good_q;
        if (!enable) begin
            state_d = LK_IDLE;
            good_d  = '0;
        end else begin
            unique case (state_q)
                LK_IDLE: begin
                    if (sync) begin
                        state_d = LK_HUNT;
                        good_d  = '0;
                    end
                end
                LK_HUNT: begin
                    if (sync) begin
                        if (!in_win) begin
                            good_d = '0;
                        end else if (good_q == GOOD_LAST) begin
                            state_d = LK_LOCKED;
                            good_d  = '0;
                        end else begin
                            good_d = good_q + 1'b1;
                        end
                    end else if (expired) begin
                        state_d = LK_IDLE;
                        good_d  = '0;
                    end
                end
                LK_LOCKED: begin
                    if (sync && !in_win) begin
                        state_d = LK_HUNT;
                        good_d  = '0;
                    end else if (expired) begin
                        state_d = LK_IDLE;
                    end
                end
                default: begin
                    state_d = LK_IDLE;
                    good_d  = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        unlock = (state_q != LK_LOCKED);
    end

    a_r6_bad_interval_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlock && sync && ((cnt_q < win_min) || (cnt_q > win_max))) |=> unlock);

    a_r7_timeout_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlock && !sync && (cnt_q >= win_max)) |=> unlock);

    a_r8_lock_only_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unlock) |-> $past(sync));

    a_r5_off_forces_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> unlock);

endmodule

// File: rtl/rx_clk_switch.sv
module rx_clk_switch (
    input  logic pll_clk,
    input  logic xtal_clk,
    input  logic rst_n,
    input  logic sel_pll,
    input  logic rx_data,
    input  logic aux_data,
    output logic mclk_out,
    output logic sdata_out
);
    logic p_req_q, p_en_q;
    logic x_req_q, x_en_q;

    // PLL side: enable only after the crystal enable has dropped
    always_ff @(negedge pll_clk or negedge rst_n) begin
        if (!rst_n) begin
            p_req_q <= 1'b0;
            p_en_q  <= 1'b0;
        end else begin
            p_req_q <= sel_pll & ~x_en_q;
            p_en_q  <= p_req_q;
        end
    end

    // Crystal side: enable only after the PLL enable has dropped
    always_ff @(negedge xtal_clk or negedge rst_n) begin
        if (!rst_n) begin
            x_req_q <= 1'b0;
            x_en_q  <= 1'b0;
        end else begin
            x_req_q <= ~sel_pll & ~p_en_q;
            x_en_q  <= x_req_q;
        end
    end

    assign mclk_out  = (pll_clk & p_en_q) | (xtal_clk & x_en_q);
    // Data follows the enable that drives the clock
    assign sdata_out = p_en_q ? rx_data : aux_data;

    a_r9_single_clock: assert property (@(posedge xtal_clk) disable iff (!rst_n)
        !(p_en_q && x_en_q));

    a_r9_xtal_waits_for_pll_off: assert property (@(negedge xtal_clk) disable iff (!rst_n)
        $rose(x_en_q) |-> !p_en_q);

endmodule

// File: rtl/rx_clk_src_sel.sv
module rx_clk_src_sel
    import rx_css_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int LOCK_CNT = 4
) (
    input  logic             xtal_clk,
    input  logic             pll_clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             frame_sync,
    input  logic             rx_data,
    input  logic             aux_data,
    input  logic [CNT_W-1:0] win_min,
    input  logic [CNT_W-1:0] win_max,
    output logic             mclk_out,
    output logic             sdata_out,
    output logic             unlock,
    output logic             pll_en
);
    logic sel_pll;

    // Mode decode: PLL power and preferred source
    always_comb begin
        unique case (cm_e'(mode))
            MODE_PLL:     begin pll_en = 1'b1; sel_pll = 1'b1;    end
            MODE_XTAL:    begin pll_en = 1'b0; sel_pll = 1'b0;    end
            MODE_AUTO:    begin pll_en = 1'b1; sel_pll = ~unlock; end
            MODE_MONITOR: begin pll_en = 1'b1; sel_pll = 1'b0;    end
        endcase
    end

    rx_lock_mon #(
        .CNT_W    (CNT_W),
        .LOCK_CNT (LOCK_CNT)
    ) u_lock_mon (
        .clk     (xtal_clk),
        .rst_n   (rst_n),
        .enable  (pll_en),
        .sync    (frame_sync),
        .win_min (win_min),
        .win_max (win_max),
        .unlock  (unlock)
    );

    rx_clk_switch u_switch (
        .pll_clk   (pll_clk),
        .xtal_clk  (xtal_clk),
        .rst_n     (rst_n),
        .sel_pll   (sel_pll),
        .rx_data   (rx_data),
        .aux_data  (aux_data),
        .mclk_out  (mclk_out),
        .sdata_out (sdata_out)
    );

endmodule

// File: tb/rx_clk_src_sel_bench.sv
`timescale 1ns/100ps
module rx_clk_src_sel_bench;
    localparam real XTAL_PERIOD = 10.0;
    localparam real PLL_PERIOD  = 14.0;
    localparam int  CNT_W       = 12;
    localparam int  GOOD_GAP    = 24;

    logic xtal_clk = 1'b0, pll_clk = 1'b0, rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic frame_sync = 1'b0, rx_data = 1'b0, aux_data = 1'b0;
    logic [CNT_W-1:0] win_min = 12'd20, win_max = 12'd28;
    logic mclk_out, sdata_out, unlock, pll_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(XTAL_PERIOD/2.0) xtal_clk = ~xtal_clk;
    always #(PLL_PERIOD/2.0)  pll_clk  = ~pll_clk;

    rx_clk_src_sel #(.CNT_W(CNT_W), .LOCK_CNT(4)) u_rx_clk_src_sel (
        .xtal_clk(xtal_clk), .pll_clk(pll_clk), .rst_n(rst_n), .mode(mode),
        .frame_sync(frame_sync), .rx_data(rx_data), .aux_data(aux_data),
        .win_min(win_min), .win_max(win_max), .mclk_out(mclk_out),
        .sdata_out(sdata_out), .unlock(unlock), .pll_en(pll_en));

    // Vector: {mode[1:0], want_lock, exp_pll_src, exp_unlock, exp_pll_en}
    localparam logic [5:0] VEC [7] = '{
        {2'b00, 1'b1, 1'b1, 1'b0, 1'b1},
        {2'b00, 1'b0, 1'b1, 1'b1, 1'b1},
        {2'b01, 1'b1, 1'b0, 1'b1, 1'b0},
        {2'b10, 1'b1, 1'b1, 1'b0, 1'b1},
        {2'b10, 1'b0, 1'b0, 1'b1, 1'b1},
        {2'b11, 1'b1, 1'b0, 1'b0, 1'b1},
        {2'b11, 1'b0, 1'b0, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse();
        @(negedge xtal_clk); frame_sync = 1'b1;
        @(negedge xtal_clk); frame_sync = 1'b0;
    endtask

    task automatic pulse_after(input int gap);
        repeat (gap - 1) @(negedge xtal_clk);
        frame_sync = 1'b1;
        @(negedge xtal_clk); frame_sync = 1'b0;
    endtask

    task automatic make_lock();
        pulse();
        for (int i = 0; i < 4; i++) pulse_after(GOOD_GAP);
    endtask

    // Counts samples where mclk_out differs from the expected source
    task automatic src_mismatch(input bit want_pll, output int bad);
        bad = 0;
        @(posedge xtal_clk); #0.5;
        for (int i = 0; i < 20; i++) begin
            if (mclk_out !== (want_pll ? pll_clk : xtal_clk)) bad++;
            #3;
        end
    endtask

    // Port-level check of clock/data pairing across a source change
    task automatic watch_switch(output int bad);
        bad = 0;
        rx_data = 1'b1; aux_data = 1'b0;
        #0.5;
        for (int i = 0; i < 150; i++) begin
            if (mclk_out && !pll_clk && !xtal_clk) bad++;
            if (mclk_out && pll_clk && !xtal_clk && sdata_out !== rx_data) bad++;
            if (mclk_out && xtal_clk && !pll_clk && sdata_out !== aux_data) bad++;
            #1;
        end
    endtask

    initial begin
        #(XTAL_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int bad;
        // R11: reset state
        #10.5;
        chk("R11 unlock in reset", unlock, 1);
        aux_data = 1'b1; rx_data = 1'b0; #0.1;
        chk("R11 sdata=aux in reset", sdata_out, 1);
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            if (mclk_out !== 1'b0) bad++;
            #1.3;
        end
        chk("R11 no clock in reset", bad, 0);
        #2.5;
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R5
        foreach (VEC[k]) begin
            mode = VEC[k][5:4];
            if (VEC[k][3]) make_lock();
            else repeat (40) @(negedge xtal_clk);
            repeat (8) @(negedge xtal_clk);
            src_mismatch(VEC[k][2], bad);
            chk($sformatf("R1/R2/R3/R4 clock source row %0d", k), bad, 0);
            rx_data = 1'b1; aux_data = 1'b0; #0.2;
            chk($sformatf("R10 data source A row %0d", k), sdata_out, VEC[k][2] ? 1 : 0);
            rx_data = 1'b0; aux_data = 1'b1; #0.2;
            chk($sformatf("R10 data source B row %0d", k), sdata_out, VEC[k][2] ? 0 : 1);
            chk($sformatf("R3/R4/R5 unlock row %0d", k), unlock, VEC[k][1]);
            chk($sformatf("R5 pll_en row %0d", k), pll_en, VEC[k][0]);
        end

        // R9 R10: switch PLL -> crystal -> PLL
        mode = 2'b00;
        repeat (10) @(negedge xtal_clk);
        mode = 2'b01;
        watch_switch(bad);
        chk("R9 R10 pll to xtal switch", bad, 0);
        mode = 2'b00;
        watch_switch(bad);
        chk("R9 R10 xtal to pll switch", bad, 0);

        // R6: window limits while locked (mode 3)
        mode = 2'b11;
        make_lock();
        chk("R6 locked before boundary test", unlock, 0);
        pulse_after(20);
        chk("R6 interval = win_min keeps lock", unlock, 0);
        pulse_after(28);
        chk("R6 interval = win_max keeps lock", unlock, 0);
        pulse_after(19);
        chk("R6 interval below win_min unlocks", unlock, 1);
        make_lock();
        pulse_after(29);
        chk("R6 R7 interval above win_max unlocks", unlock, 1);

        // R7: timeout edge
        make_lock();
        repeat (27) @(negedge xtal_clk);
        chk("R7 still locked before win_max", unlock, 0);
        @(negedge xtal_clk);
        chk("R7 unlock at win_max edges", unlock, 1);

        // R8: reference pulse, run restart on bad interval
        repeat (5) @(negedge xtal_clk);
        pulse();
        chk("R8 reference pulse alone", unlock, 1);
        for (int i = 0; i < 3; i++) pulse_after(GOOD_GAP);
        chk("R8 three good intervals not enough", unlock, 1);
        pulse_after(18);
        chk("R8 bad interval during hunt", unlock, 1);
        for (int i = 0; i < 3; i++) pulse_after(GOOD_GAP);
        chk("R8 count restarted after bad interval", unlock, 1);
        pulse_after(GOOD_GAP);
        chk("R8 fourth good interval locks", unlock, 0);

        // R5: mode 1 forces unlock at next edge and ignores pulses
        @(negedge xtal_clk); mode = 2'b01;
        @(negedge xtal_clk);
        chk("R5 mode 1 unlock next edge", unlock, 1);
        make_lock();
        chk("R5 pulses ignored in mode 1", unlock, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule